// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block carries doorbell signals between two processors. The sending processor owns one 32-bit register port and the receiving processor owns another. Each side sees the same set of per-channel windows, 32 bytes each, starting at offset 0, plus a frame-level area from offset 0xF80. A sender raises flag bits in a channel by writing a one to each bit it wants set. The receiver reads those flags, clears them by writing ones, and masks chosen bits so that they do not raise its interrupt.

Before it rings any doorbell, the sender writes 1 to an access-request register and polls an access-ready register until that register is nonzero. While ready is low, writes to the set registers are dropped. The receiver interrupt is the OR, over all channels, of the flag bits that are not masked. It leaves the block through one register stage. Both frames also expose a read-only channel count and a revision word.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, all flags read 0, every mask bit reads 1, `rx_irq` is 0, and access-request and access-ready read 0.
- R2: A sender write to window offset 0x0C while access-ready is high ORs the write data into that channel's flags. Sender offset 0x00 and receiver offset 0x00 both read the flags.
- R3: A sender write to offset 0x0C while access-ready is low leaves the flags unchanged.
- R4: A receiver write to offset 0x08 clears each flag bit written as 1. Writing all ones empties the channel.
- R5: When a set and a clear reach the same channel in the same cycle, bits present in both end up set.
- R6: Receiver offset 0x14 sets mask bits and offset 0x18 clears mask bits, with write-one semantics. Offset 0x10 reads the mask. Offset 0x04 reads flags AND NOT mask.
- R7: `rx_irq` equals, one cycle later, the OR over all channels of the masked status.
- R8: Bit 0 of sender offset 0xF88 is access-request and reads back. Access-ready at 0xF8C bit 0 rises exactly two clock edges after the edge that writes request 1. It falls on the same edge that writes request 0.
- R9: Offset 0xF80 reads the channel count on both frames. Offset 0xFCC reads 0x10 plus the minor-revision parameter: major revision in bits 7:4, minor in bits 3:0. On the receiver frame, 0xF88 and 0xF8C read 0.
- R10: Windows whose index is at or above the channel count read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_we | input | 1 | Sender write strobe |
| s_addr | input | 12 | Sender byte address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational from s_addr) |
| r_we | input | 1 | Receiver write strobe |
| r_addr | input | 12 | Receiver byte address |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data (combinational from r_addr) |
| rx_irq | output | 1 | Registered receiver interrupt |

## Verification
On every cycle, the embedded properties check the following:
- set bits always land, and set wins over clear;
- cleared bits vanish when no set competes;
- flags and masks hold when no write hits them;
- the interrupt tracks the masked status one cycle late;
- ready never stands without a request and rises only after two cycles of request.

Only the bench scenarios can show the rest: the address decode, the read values of each offset on each frame, and that set writes are dropped while ready is low. They also cover the silence of out-of-range windows and the exact cycle on which ready and the interrupt change.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WIN_SH   = 5;   // 32-byte windows
  localparam int unsigned IDX_W    = ADDR_W - WIN_SH;
  localparam logic [ADDR_W-1:0] FRAME_BASE = 12'hF80;

  // word offsets inside a window (byte offset / 4)
  localparam logic [2:0] W_STAT    = 3'd0;
  localparam logic [2:0] W_MSTAT   = 3'd1;
  localparam logic [2:0] W_CLR     = 3'd2;
  localparam logic [2:0] W_SET     = 3'd3;
  localparam logic [2:0] W_MASK    = 3'd4;
  localparam logic [2:0] W_MSET    = 3'd5;
  localparam logic [2:0] W_MCLR    = 3'd6;

  // frame-level byte offsets
  localparam logic [ADDR_W-1:0] A_CFG   = 12'hF80;
  localparam logic [ADDR_W-1:0] A_AREQ  = 12'hF88;
  localparam logic [ADDR_W-1:0] A_ARDY  = 12'hF8C;
  localparam logic [ADDR_W-1:0] A_REVID = 12'hFCC;

  function automatic logic [DATA_W-1:0] rev_word(input logic [3:0] minor);
    return {{(DATA_W-8){1'b0}}, 4'h1, minor};
  endfunction
endpackage

// File: rtl/doorbell_chan.sv
module doorbell_chan
  import doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              mset_en,
  input  logic [DATA_W-1:0] mset_bits,
  input  logic              mclr_en,
  input  logic [DATA_W-1:0] mclr_bits,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] mask
);
  logic [DATA_W-1:0] flags_d, mask_d;
  logic [DATA_W-1:0] clr_v, set_v, mclr_v, mset_v;

  always_comb begin
    clr_v   = clr_en  ? clr_bits  : '0;
    set_v   = set_en  ? set_bits  : '0;
    mclr_v  = mclr_en ? mclr_bits : '0;
    mset_v  = mset_en ? mset_bits : '0;
    flags_d = (flags & ~clr_v) | set_v;   // set has priority
    mask_d  = (mask & ~mclr_v) | mset_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '1;
    end else begin
      if (set_en || clr_en)   flags <= flags_d;
      if (mset_en || mclr_en) mask  <= mask_d;
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((flags & $past(set_bits)) == $past(set_bits))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((flags & $past(clr_bits)) == '0)); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(flags)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mset_en && !mclr_en) |=> $stable(mask)); // R6
endmodule

// File: rtl/doorbell_access.sv
module doorbell_access (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic req,
  output logic ready
);
  logic       req_d;
  logic [1:0] stg, stg_d;

  always_comb begin
    req_d = wr_en ? wr_bit : req;
    stg_d = {stg[0] & req, req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      stg <= 2'b00;
    end else begin
      req <= req_d;
      stg <= stg_d;
    end
  end

  assign ready = stg[1] & req;

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req); // R8
  AST_READY_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(req, 1) && $past(req, 2))); // R8
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter logic [3:0]  MINOR = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_we,
  input  logic [11:0]       s_addr,
  input  logic [31:0]       s_wdata,
  output logic [31:0]       s_rdata,
  input  logic              r_we,
  input  logic [11:0]       r_addr,
  input  logic [31:0]       r_wdata,
  output logic [31:0]       r_rdata,
  output logic              rx_irq
);
  logic [NCH-1:0][DATA_W-1:0] flags_all, mask_all;
  logic [NCH-1:0]             pend;
  logic                       acc_req, acc_rdy;
  logic                       irq_d;

  logic             s_win, r_win;
  logic [IDX_W-1:0] s_idx, r_idx;
  logic [2:0]       s_off, r_off;

  assign s_win = s_addr < FRAME_BASE;
  assign r_win = r_addr < FRAME_BASE;
  assign s_idx = s_addr[ADDR_W-1:WIN_SH];
  assign r_idx = r_addr[ADDR_W-1:WIN_SH];
  assign s_off = s_addr[4:2];
  assign r_off = r_addr[4:2];

  doorbell_access u_access (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (s_we && (s_addr == A_AREQ)),
    .wr_bit (s_wdata[0]),
    .req    (acc_req),
    .ready  (acc_rdy)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic s_hit, r_hit;
    assign s_hit = s_we && s_win && (s_idx == IDX_W'(i));
    assign r_hit = r_we && r_win && (r_idx == IDX_W'(i));

    doorbell_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (s_hit && (s_off == W_SET) && acc_rdy),
      .set_bits  (s_wdata),
      .clr_en    (r_hit && (r_off == W_CLR)),
      .clr_bits  (r_wdata),
      .mset_en   (r_hit && (r_off == W_MSET)),
      .mset_bits (r_wdata),
      .mclr_en   (r_hit && (r_off == W_MCLR)),
      .mclr_bits (r_wdata),
      .flags     (flags_all[i]),
      .mask      (mask_all[i])
    );
    assign pend[i] = |(flags_all[i] & ~mask_all[i]);
  end

  // sender read mux
  always_comb begin
    s_rdata = '0;
    if (s_win) begin
      for (int i = 0; i < NCH; i++)
        if (s_idx == IDX_W'(i) && s_off == W_STAT) s_rdata = flags_all[i];
    end else begin
      case (s_addr)
        A_CFG:   s_rdata = DATA_W'(NCH);
        A_AREQ:  s_rdata = {{(DATA_W-1){1'b0}}, acc_req};
        A_ARDY:  s_rdata = {{(DATA_W-1){1'b0}}, acc_rdy};
        A_REVID: s_rdata = rev_word(MINOR);
        default: s_rdata = '0;
      endcase
    end
  end

  // receiver read mux
  always_comb begin
    r_rdata = '0;
    if (r_win) begin
      for (int i = 0; i < NCH; i++) begin
        if (r_idx == IDX_W'(i)) begin
          case (r_off)
            W_STAT:  r_rdata = flags_all[i];
            W_MSTAT: r_rdata = flags_all[i] & ~mask_all[i];
            W_MASK:  r_rdata = mask_all[i];
            default: r_rdata = '0;
          endcase
        end
      end
    end else begin
      case (r_addr)
        A_CFG:   r_rdata = DATA_W'(NCH);
        A_REVID: r_rdata = rev_word(MINOR);
        default: r_rdata = '0;
      endcase
    end
  end

  assign irq_d = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= irq_d;
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> rx_irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> !rx_irq); // R7
  AST_NO_SET_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rdy && !r_we) |=> $stable(flags_all)); // R3
endmodule

// File: tb/doorbell_mbox_test.sv
`timescale 1ns/1ps
module doorbell_mbox_test;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic s_we = 0, r_we = 0;
  logic [11:0] s_addr = 0, r_addr = 0;
  logic [31:0] s_wdata = 0, r_wdata = 0;
  logic [31:0] s_rdata, r_rdata;
  logic rx_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_flags [NCH];
  logic [31:0] m_mask  [NCH];
  bit m_req, m_rdy;

  always #10 clk = ~clk;

  doorbell_mbox #(.NCH(NCH), .MINOR(4'h0)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .rx_irq(rx_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input bit rx, input logic [11:0] a);
    int idx = int'(a[11:5]);
    int off = int'(a[4:2]);
    if (a < 12'hF80) begin
      if (idx >= NCH) return 0;
      if (off == 0) return m_flags[idx];
      if (rx && off == 1) return m_flags[idx] & ~m_mask[idx];
      if (rx && off == 4) return m_mask[idx];
      return 0;
    end
    if (a == 12'hF80) return NCH;
    if (a == 12'hFCC) return 32'h10;
    if (!rx && a == 12'hF88) return {31'b0, m_req};
    if (!rx && a == 12'hF8C) return {31'b0, m_rdy};
    return 0;
  endfunction

  function automatic bit exp_irq();
    bit any = 0;
    for (int i = 0; i < NCH; i++) any |= |(m_flags[i] & ~m_mask[i]);
    return any;
  endfunction

  task automatic wr(input bit rx, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_we = 1; r_addr = a; r_wdata = d; end
    else    begin s_we = 1; s_addr = a; s_wdata = d; end
    @(negedge clk);
    s_we = 0; r_we = 0;
  endtask

  task automatic wr_both(input logic [11:0] sa, input logic [31:0] sd,
                         input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    s_we = 1; s_addr = sa; s_wdata = sd;
    r_we = 1; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    s_we = 0; r_we = 0;
  endtask

  task automatic rd(input bit rx, input logic [11:0] a, input string req);
    if (rx) r_addr = a; else s_addr = a;
    #1;
    check(req, rx ? r_rdata : s_rdata, exp_rd(rx, a));
  endtask

  task automatic apply_model(input int op, input int ch, input logic [31:0] d, input logic [31:0] d2);
    if (ch >= NCH) return;
    case (op)
      0: if (m_rdy) m_flags[ch] |= d;
      1: m_flags[ch] &= ~d;
      2: m_mask[ch] |= d;
      3: m_mask[ch] &= ~d;
      default: m_flags[ch] = (m_flags[ch] & ~d2) | d;
    endcase
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin m_flags[i] = 0; m_mask[i] = '1; end
    m_req = 0; m_rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NCH; i++) begin
      rd(0, 12'(i*32), "R1 flags");
      rd(1, 12'(i*32 + 16), "R1 mask");
    end
    rd(0, 12'hF88, "R1 req");
    rd(0, 12'hF8C, "R1 ready");
    check("R1 irq", {31'b0, rx_irq}, 0);

    // R9 config and revision
    rd(0, 12'hF80, "R9 cfg s");
    rd(1, 12'hF80, "R9 cfg r");
    rd(0, 12'hFCC, "R9 id s");
    rd(1, 12'hFCC, "R9 id r");
    rd(1, 12'hF88, "R9 rx areq");

    // R3 set while not ready
    wr(0, 12'h00C, 32'h0000_00FF);
    rd(0, 12'h000, "R3 ignored set");
    rd(1, 12'h000, "R3 ignored set rx");

    // R8 handshake timing: write edge k, return at k+0.5
    wr(0, 12'hF88, 1); m_req = 1;
    rd(0, 12'hF88, "R8 req readback");
    rd(0, 12'hF8C, "R8 ready k+0.5");
    @(negedge clk);
    rd(0, 12'hF8C, "R8 ready k+1.5");
    @(negedge clk); m_rdy = 1;
    rd(0, 12'hF8C, "R8 ready k+2.5");

    // R2 set, R7 irq timing
    wr(1, 12'h018 + 12'h020, 32'h0000_000F);   // unmask ch1 bits 3:0
    m_mask[1] &= ~32'hF;
    wr(0, 12'h02C, 32'h0000_0005); m_flags[1] |= 5;
    rd(0, 12'h020, "R2 sender status");
    rd(1, 12'h020, "R2 receiver status");
    rd(1, 12'h024, "R6 masked status");
    check("R7 irq not yet", {31'b0, rx_irq}, 0);
    @(negedge clk);
    check("R7 irq raised", {31'b0, rx_irq}, 1);

    // R5 simultaneous set and clear
    wr_both(12'h02C, 32'h0000_0030, 12'h028, 32'h0000_0031);
    m_flags[1] = (m_flags[1] & ~32'h31) | 32'h30;
    rd(1, 12'h020, "R5 set wins");

    // R4 clear all
    wr(1, 12'h028, 32'hFFFF_FFFF); m_flags[1] = 0;
    rd(1, 12'h020, "R4 clear all");
    @(negedge clk);
    check("R7 irq dropped", {31'b0, rx_irq}, 0);

    // R10 out of range window
    wr(0, 12'h0AC, 32'hDEAD_BEEF);
    wr(1, 12'h0B8, 32'hFFFF_FFFF);
    rd(0, 12'h0A0, "R10 oor s");
    rd(1, 12'h0B0, "R10 oor mask");
    for (int i = 0; i < NCH; i++) rd(0, 12'(i*32), "R10 no alias");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 4));
      int ch = int'($urandom_range(0, NCH + 1));
      logic [31:0] d = $urandom() & ($urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0000_00FF);
      logic [31:0] d2 = $urandom();
      bit irq_before = exp_irq();
      logic [11:0] base = 12'(ch * 32);
      case (op)
        0: wr(0, base + 12'h0C, d);
        1: wr(1, base + 12'h08, d);
        2: wr(1, base + 12'h14, d);
        3: wr(1, base + 12'h18, d);
        default: wr_both(base + 12'h0C, d, base + 12'h08, d2);
      endcase
      apply_model(op, ch, d, d2);
      check("R7 irq lag", {31'b0, rx_irq}, {31'b0, irq_before});
      rd(0, base, (op == 0) ? "R2 rand set" : (ch >= NCH ? "R10 rand" : "R5 rand"));
      rd(1, base + 12'h04, "R6 rand masked");
      rd(1, base + 12'h10, "R6 rand mask");
      rd(1, base, "R4 rand status");
      @(negedge clk);
      check("R7 irq rand", {31'b0, rx_irq}, {31'b0, exp_irq()});
    end

    // R8 release
    wr(0, 12'hF88, 0); m_req = 0; m_rdy = 0;
    rd(0, 12'hF8C, "R8 ready drop");
    rd(0, 12'hF88, "R8 req cleared");
    wr(0, 12'h00C, 32'h8000_0000);
    rd(0, 12'h000, "R3 ignored after release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule